// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps a set of 64-bit event counters for an Ethernet MAC. The MAC side hands over one packed flag vector per frame in each direction: 25 bits for transmit and 29 bits for receive, each qualified by its own one-cycle strobe. The block decodes every strobed vector into increments for the counters it touches. These cover frame-type counters (good frames, broadcast, multicast, control, pause, VLAN), error counters (FCS errors, underruns, bad opcodes, length/type errors, runts), six size-bin counters per direction and one byte counter per direction. Counters saturate at all-ones instead of wrapping, and the synchronous active-low reset clears them.

A host reads a counter by pulsing a request with a 6-bit counter address. After a fixed latency the block returns the selected counter as two 32-bit words on consecutive cycles, low word first. The whole 64-bit value is captured in the cycle the low word is presented, so the two halves always belong to the same value. A request that arrives while a two-word read is still in flight is dropped. Everything runs on one clock.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter reads as zero and `rd_valid` and `rd_hi` are low.
- R2: Each receive strobe whose good flag (bit 0) is set adds one to address 0x00. On the same condition it also adds one to 0x02 if bit 3 (broadcast) is set, 0x03 if bit 4 (multicast), 0x0A if bit 19 (control), 0x0C if bit 21 (VLAN), 0x0D if bit 26 (flow-control frame) and 0x0F if bit 20 (out of bounds). None of these six counters moves when bit 0 is clear.
- R3: These receive counters move on their flag whether or not the good flag is set: 0x01 counts bit 2 (FCS error), 0x0B counts bit 28 (length/type out of range) and 0x0E counts bit 27 (bad opcode). A receive frame whose length field is below 64 adds one to 0x11 when bit 2 is set and to 0x10 when it is clear.
- R4: A good receive frame whose length field (bits 18:5) falls in one of the ranges 64, 65-127, 128-255, 256-511, 512-1023 or 1024 and above adds one to 0x04, 0x05, 0x06, 0x07, 0x08 or 0x09 respectively. Lengths below 64 touch no bin.
- R5: Each transmit strobe with bit 0 (successful) set adds one to 0x20. On the same condition it also adds one to 0x21 if bit 1 (broadcast) is set, 0x22 if bit 2 (multicast), 0x24 if bit 4 (control), 0x2B if bit 19 (VLAN), 0x2C if bit 24 (pause sent), and to 0x2D when the length (bits 18:5) exceeds MAX_FRAME (1518). It also adds one to the size bins 0x25..0x2A, which use the same ranges as R4. Bit 3 (underrun) adds one to 0x23 regardless of bit 0.
- R6: On every strobe, the 14-bit length field is added to the receive byte counter (0x12) for receive and to the transmit byte counter (0x13) for transmit, regardless of any flag.
- R7: A request sampled at a clock edge puts the low word on `rd_data` with `rd_valid` high and `rd_hi` low RD_LAT (6) edges later. The high word follows on the next edge with `rd_hi` high, and `rd_valid` drops on the edge after that.
- R8: A request sampled while a read is in progress is ignored: it produces no extra words and does not change the address being returned.
- R9: A counter that would pass its maximum value (all ones over CNT_W bits) stays at that maximum.
- R10: Addresses outside 0x00..0x13 and 0x20..0x2D return zero in both words.
- R11: A vector presented while its strobe is low changes no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for datapath and host side |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_stat_valid | input | 1 | Strobe qualifying the transmit vector |
| tx_stat_vec | input | 25 | Transmit per-frame flag vector |
| rx_stat_valid | input | 1 | Strobe qualifying the receive vector |
| rx_stat_vec | input | 29 | Receive per-frame flag vector |
| host_req | input | 1 | One-cycle read request |
| host_addr | input | 6 | Counter address for the request |
| rd_valid | output | 1 | A read word is on `rd_data` |
| rd_hi | output | 1 | The word on `rd_data` is the high half |
| rd_data | output | 32 | Read data word |

## Verification
The hardest condition to reach from the ports is saturation. At 64 bits no counter can be filled in any practical run, so the bench places a second instance with a 20-bit counter width beside the main one. Both instances get the same stimulus, and the bench drives 70 back-to-back transmit vectors with the largest length field, which pushes the transmit byte counter past its ceiling. Every read then compares the narrow instance against the reference value clamped at its maximum. A second hard case is a request that lands inside a read burst. The bench issues it three cycles after an accepted request, to an address holding a different value, and checks that only one burst appears and that it carries the first counter.

// File: rtl/mac_stat_pkg.sv
// Package: shared constants for the statistics counter bank.
// Holds vector field positions (fixed by the producing MAC), counter slot
// numbers (slot = address for receive, address - TX_BASE + NUM_RX for
// transmit) and the length-to-bin helper.
package mac_stat_pkg;
    localparam int LEN_W     = 14;
    localparam int TXV_W     = 25;
    localparam int RXV_W     = 29;
    localparam int NUM_BINS  = 6;
    localparam int MIN_FRAME = 64;
    localparam int NUM_RX    = 20;
    localparam int NUM_TX    = 14;
    localparam int NUM_CNT   = NUM_RX + NUM_TX;
    localparam int TX_BASE   = 32;
    localparam int LEN_LSB   = 5;

    // receive vector flag positions
    localparam int RXB_GOOD  = 0;
    localparam int RXB_FCS   = 2;
    localparam int RXB_BCAST = 3;
    localparam int RXB_MCAST = 4;
    localparam int RXB_CTRL  = 19;
    localparam int RXB_OOB   = 20;
    localparam int RXB_VLAN  = 21;
    localparam int RXB_PAUSE = 26;
    localparam int RXB_BADOP = 27;
    localparam int RXB_LTR   = 28;

    // transmit vector flag positions
    localparam int TXB_OK    = 0;
    localparam int TXB_BCAST = 1;
    localparam int TXB_MCAST = 2;
    localparam int TXB_UNDER = 3;
    localparam int TXB_CTRL  = 4;
    localparam int TXB_VLAN  = 19;
    localparam int TXB_PAUSE = 24;

    // receive-side slots (equal to their host address)
    localparam int C_RX_OK    = 0;
    localparam int C_RX_FCS   = 1;
    localparam int C_RX_BCAST = 2;
    localparam int C_RX_MCAST = 3;
    localparam int C_RX_BIN0  = 4;
    localparam int C_RX_CTRL  = 10;
    localparam int C_RX_LTR   = 11;
    localparam int C_RX_VLAN  = 12;
    localparam int C_RX_PAUSE = 13;
    localparam int C_RX_BADOP = 14;
    localparam int C_RX_OVER  = 15;
    localparam int C_RX_UNDER = 16;
    localparam int C_RX_FRAG  = 17;
    localparam int C_RX_BYTES = 18;
    localparam int C_TX_BYTES = 19;

    // transmit-side slots, relative to the transmit group
    localparam int T_OK    = 0;
    localparam int T_BCAST = 1;
    localparam int T_MCAST = 2;
    localparam int T_UNDER = 3;
    localparam int T_CTRL  = 4;
    localparam int T_BIN0  = 5;
    localparam int T_VLAN  = 11;
    localparam int T_PAUSE = 12;
    localparam int T_OVER  = 13;

    // one-hot size bin of a frame length; zero below the minimum frame
    function automatic logic [NUM_BINS-1:0] size_bin(input logic [LEN_W-1:0] len);
        logic hit;
        size_bin = '0;
        hit      = 1'b0;
        if (len == LEN_W'(MIN_FRAME)) begin
            size_bin[0] = 1'b1;
        end else if (len > LEN_W'(MIN_FRAME)) begin
            for (int b = 1; b < NUM_BINS; b++) begin
                if (!hit && ((b == NUM_BINS - 1) || (len < LEN_W'(MIN_FRAME << b)))) begin
                    size_bin[b] = 1'b1;
                    hit         = 1'b1;
                end
            end
        end
    endfunction
endpackage

// File: rtl/mac_stat_rx_decode.sv
// Module: receive vector decoder.
// Turns one strobed receive vector into a per-slot increment mask and a
// byte amount. Purely combinational; clk/rst_n only clock its checks.
// Assumes the vector is stable while rx_valid is high.
module mac_stat_rx_decode
    import mac_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [RXV_W-1:0]     rx_vec,
    output logic [NUM_RX-1:0]    rx_inc,
    output logic [LEN_W-1:0]     rx_len
);
    logic [NUM_BINS-1:0] bin;
    logic                good;
    logic                runt;
    logic                unused_rx;

    assign unused_rx = ^{rx_vec[1], rx_vec[25:22]};
    assign rx_len    = rx_vec[LEN_LSB +: LEN_W];
    assign bin       = size_bin(rx_len);
    assign good      = rx_vec[RXB_GOOD];
    assign runt      = rx_len < LEN_W'(MIN_FRAME);

    // build the increment mask for one receive frame
    always_comb begin
        rx_inc = '0;
        if (rx_valid) begin
            rx_inc[C_RX_OK]    = good;
            rx_inc[C_RX_FCS]   = rx_vec[RXB_FCS];
            rx_inc[C_RX_BCAST] = good & rx_vec[RXB_BCAST];
            rx_inc[C_RX_MCAST] = good & rx_vec[RXB_MCAST];
            rx_inc[C_RX_CTRL]  = good & rx_vec[RXB_CTRL];
            rx_inc[C_RX_LTR]   = rx_vec[RXB_LTR];
            rx_inc[C_RX_VLAN]  = good & rx_vec[RXB_VLAN];
            rx_inc[C_RX_PAUSE] = good & rx_vec[RXB_PAUSE];
            rx_inc[C_RX_BADOP] = rx_vec[RXB_BADOP];
            rx_inc[C_RX_OVER]  = good & rx_vec[RXB_OOB];
            rx_inc[C_RX_UNDER] = runt & ~rx_vec[RXB_FCS];
            rx_inc[C_RX_FRAG]  = runt & rx_vec[RXB_FCS];
            rx_inc[C_RX_BYTES] = 1'b1;
            for (int b = 0; b < NUM_BINS; b++) begin
                rx_inc[C_RX_BIN0 + b] = good & bin[b];
            end
        end
    end

    // R4: a frame lands in at most one receive size bin
    assert_one_rx_bin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_inc[C_RX_BIN0 +: NUM_BINS]));

    // R2: a receive frame without the good flag moves no good-gated counter
    assert_rx_good_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_vec[RXB_GOOD]) |->
        (rx_inc[C_RX_OK] == 1'b0 && rx_inc[C_RX_BIN0 +: NUM_BINS] == '0));
endmodule

// File: rtl/mac_stat_tx_decode.sv
// Module: transmit vector decoder.
// Turns one strobed transmit vector into a per-slot increment mask for the
// transmit group plus the byte-counter enable and amount. Combinational.
module mac_stat_tx_decode
    import mac_stat_pkg::*;
#(
    parameter int MAX_FRAME = 1518
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_valid,
    input  logic [TXV_W-1:0]     tx_vec,
    output logic [NUM_TX-1:0]    tx_inc,
    output logic                 tx_byte_en,
    output logic [LEN_W-1:0]     tx_len
);
    logic [NUM_BINS-1:0] bin;
    logic                ok;
    logic                unused_tx;

    assign unused_tx  = ^tx_vec[23:20];
    assign tx_len     = tx_vec[LEN_LSB +: LEN_W];
    assign bin        = size_bin(tx_len);
    assign ok         = tx_vec[TXB_OK];
    assign tx_byte_en = tx_valid;

    // build the increment mask for one transmit frame
    always_comb begin
        tx_inc = '0;
        if (tx_valid) begin
            tx_inc[T_OK]    = ok;
            tx_inc[T_BCAST] = ok & tx_vec[TXB_BCAST];
            tx_inc[T_MCAST] = ok & tx_vec[TXB_MCAST];
            tx_inc[T_UNDER] = tx_vec[TXB_UNDER];
            tx_inc[T_CTRL]  = ok & tx_vec[TXB_CTRL];
            tx_inc[T_VLAN]  = ok & tx_vec[TXB_VLAN];
            tx_inc[T_PAUSE] = ok & tx_vec[TXB_PAUSE];
            tx_inc[T_OVER]  = ok & (tx_len > LEN_W'(MAX_FRAME));
            for (int b = 0; b < NUM_BINS; b++) begin
                tx_inc[T_BIN0 + b] = ok & bin[b];
            end
        end
    end

    // R5: a frame lands in at most one transmit size bin
    assert_one_tx_bin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_inc[T_BIN0 +: NUM_BINS]));
endmodule

// File: rtl/mac_stat_counter.sv
// Module: one saturating statistics counter.
// Adds amt when en is high; clamps at all ones; clears on reset.
// Assumes AMT_W <= CNT_W.
module mac_stat_counter #(
    parameter int CNT_W = 64,
    parameter int AMT_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [AMT_W-1:0]  amt,
    output logic [CNT_W-1:0]  value
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] next_val;

    assign sum      = {1'b0, value} + (CNT_W + 1)'(amt);
    assign next_val = sum[CNT_W] ? TOP : sum[CNT_W-1:0];

    // register the count, clamping on carry out
    always_ff @(posedge clk) begin
        if (!rst_n)  value <= '0;
        else if (en) value <= next_val;
    end

    // R9: the count never goes backwards, so it cannot wrap
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> value >= $past(value));

    // R11: without an enable the count holds
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(value));

    // R9: a nonzero add below the ceiling always moves the count
    assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && amt != '0 && value != TOP) |=> value != $past(value));
endmodule

// File: rtl/mac_stat_reader.sv
// Module: host read sequencer.
// Accepts one request at a time, waits RD_LAT edges, then returns the
// selected counter as low word and high word on consecutive cycles.
// The full value is captured when the low word goes out. Requests while
// busy are dropped. Assumes CNT_W <= 2*WORD_W and RD_LAT >= 1.
module mac_stat_reader #(
    parameter int CNT_W   = 64,
    parameter int NUM_RX  = 20,
    parameter int NUM_TX  = 14,
    parameter int TX_BASE = 32,
    parameter int ADDR_W  = 6,
    parameter int WORD_W  = 32,
    parameter int RD_LAT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  values [NUM_RX + NUM_TX],
    output logic              rd_valid,
    output logic              rd_hi,
    output logic [WORD_W-1:0] rd_data
);
    localparam int NUM_CNT = NUM_RX + NUM_TX;
    localparam int IDX_W   = $clog2(NUM_CNT);
    localparam int TICK_W  = $clog2(RD_LAT + 2);
    localparam int RD_W    = 2 * WORD_W;
    localparam logic [ADDR_W-1:0] RX_END = ADDR_W'(NUM_RX);
    localparam logic [ADDR_W-1:0] TX_LO  = ADDR_W'(TX_BASE);
    localparam logic [ADDR_W-1:0] TX_END = ADDR_W'(TX_BASE + NUM_TX);
    localparam logic [TICK_W-1:0] T_LO   = TICK_W'(RD_LAT);
    localparam logic [TICK_W-1:0] T_HI   = TICK_W'(RD_LAT + 1);

    logic              busy_q;
    logic [TICK_W-1:0] tick_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] hold_q;
    logic [IDX_W-1:0]  idx;
    logic              map_ok;
    logic [RD_W-1:0]   sel_ext;

    // map the latched address onto a counter slot
    always_comb begin
        map_ok = 1'b0;
        idx    = '0;
        if (addr_q < RX_END) begin
            map_ok = 1'b1;
            idx    = IDX_W'(addr_q);
        end else if (addr_q >= TX_LO && addr_q < TX_END) begin
            map_ok = 1'b1;
            idx    = IDX_W'(addr_q - TX_LO) + IDX_W'(NUM_RX);
        end
    end

    // zero-extend the selected counter to two words
    assign sel_ext = map_ok ? RD_W'(values[idx]) : '0;

    // request acceptance, latency count and two-word output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            tick_q   <= '0;
            addr_q   <= '0;
            hold_q   <= '0;
            rd_valid <= 1'b0;
            rd_hi    <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (!busy_q) begin
                rd_valid <= 1'b0;
                rd_hi    <= 1'b0;
                rd_data  <= '0;
                if (req) begin
                    busy_q <= 1'b1;
                    tick_q <= TICK_W'(1);
                    addr_q <= addr;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
                if (tick_q == T_LO) begin
                    rd_valid <= 1'b1;
                    rd_hi    <= 1'b0;
                    rd_data  <= sel_ext[WORD_W-1:0];
                    hold_q   <= sel_ext[RD_W-1:WORD_W];
                end else if (tick_q == T_HI) begin
                    rd_hi   <= 1'b1;
                    rd_data <= hold_q;
                    busy_q  <= 1'b0;
                end
            end
        end
    end

    // R7: a low word is always followed by its high word
    assert_low_then_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_hi) |=> (rd_valid && rd_hi));

    // R7: the burst ends right after the high word
    assert_burst_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> !rd_valid);

    // R8: the address being served cannot change mid-read
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && tick_q != T_HI) |=> $stable(addr_q));
endmodule

// File: rtl/mac_stat_bank.sv
// Module: statistics counter bank top.
// Decodes per-frame transmit and receive vectors into saturating counters
// and serves host reads of any counter as two 32-bit words.
// Single clock; synchronous active-low reset.
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int MAX_FRAME = 1518,
    parameter int RD_LAT    = 6,
    parameter int ADDR_W    = 6,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_stat_valid,
    input  logic [24:0]       tx_stat_vec,
    input  logic              rx_stat_valid,
    input  logic [28:0]       rx_stat_vec,
    input  logic              host_req,
    input  logic [5:0]        host_addr,
    output logic              rd_valid,
    output logic              rd_hi,
    output logic [31:0]       rd_data
);
    logic [NUM_RX-1:0]  rx_inc;
    logic [NUM_TX-1:0]  tx_inc;
    logic               tx_byte_en;
    logic [LEN_W-1:0]   rx_len;
    logic [LEN_W-1:0]   tx_len;
    logic [NUM_CNT-1:0] en;
    logic [CNT_W-1:0]   values [NUM_CNT];

    mac_stat_rx_decode u_rx_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_stat_valid),
        .rx_vec   (rx_stat_vec),
        .rx_inc   (rx_inc),
        .rx_len   (rx_len)
    );

    mac_stat_tx_decode #(.MAX_FRAME(MAX_FRAME)) u_tx_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_valid   (tx_stat_valid),
        .tx_vec     (tx_stat_vec),
        .tx_inc     (tx_inc),
        .tx_byte_en (tx_byte_en),
        .tx_len     (tx_len)
    );

    // merge both masks; the transmit byte counter sits in the receive range
    always_comb begin
        en             = {tx_inc, rx_inc};
        en[C_TX_BYTES] = tx_byte_en;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic [LEN_W-1:0] amt;
        if (i == C_RX_BYTES) begin : g_rxb
            assign amt = rx_len;
        end else if (i == C_TX_BYTES) begin : g_txb
            assign amt = tx_len;
        end else begin : g_evt
            assign amt = LEN_W'(1);
        end
        mac_stat_counter #(.CNT_W(CNT_W), .AMT_W(LEN_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en[i]),
            .amt   (amt),
            .value (values[i])
        );
    end

    mac_stat_reader #(
        .CNT_W   (CNT_W),
        .NUM_RX  (NUM_RX),
        .NUM_TX  (NUM_TX),
        .TX_BASE (TX_BASE),
        .ADDR_W  (ADDR_W),
        .WORD_W  (WORD_W),
        .RD_LAT  (RD_LAT)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (host_req),
        .addr     (host_addr),
        .values   (values),
        .rd_valid (rd_valid),
        .rd_hi    (rd_hi),
        .rd_data  (rd_data)
    );

    // R1: nothing is presented in the cycle after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !rd_hi));
endmodule

// File: tb/mac_stat_bank_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected values, a monitor checks words.
module mac_stat_bank_bench;
    localparam longint unsigned SAT_MAX = 64'hFFFFF;  // 20-bit instance ceiling

    localparam logic [28:0] F_GOOD = 29'h1,       F_BAD  = 29'h2;
    localparam logic [28:0] F_FCS  = 29'h4,       F_BC   = 29'h8;
    localparam logic [28:0] F_MC   = 29'h10,      F_CTL  = 29'h1 << 19;
    localparam logic [28:0] F_OOB  = 29'h1 << 20, F_VLAN = 29'h1 << 21;
    localparam logic [28:0] F_FC   = 29'h1 << 26, F_BOP  = 29'h1 << 27;
    localparam logic [28:0] F_LTR  = 29'h1 << 28;
    localparam logic [24:0] G_OK   = 25'h1,  G_BC  = 25'h2,  G_MC = 25'h4;
    localparam logic [24:0] G_UND  = 25'h8,  G_CTL = 25'h10;
    localparam logic [24:0] G_VLAN = 25'h1 << 19, G_PAU = 25'h1 << 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0, rx_valid = 1'b0, host_req = 1'b0;
    logic [24:0] tx_vec = '0;
    logic [28:0] rx_vec = '0;
    logic [5:0]  host_addr = '0;
    logic        rd_valid, rd_hi, s_valid, s_hi;
    logic [31:0] rd_data, s_data;

    always #2.5 clk = ~clk;

    mac_stat_bank u_mac_stat_bank (
        .clk(clk), .rst_n(rst_n), .tx_stat_valid(tx_valid), .tx_stat_vec(tx_vec),
        .rx_stat_valid(rx_valid), .rx_stat_vec(rx_vec), .host_req(host_req),
        .host_addr(host_addr), .rd_valid(rd_valid), .rd_hi(rd_hi), .rd_data(rd_data));

    mac_stat_bank #(.CNT_W(20)) u_sat (
        .clk(clk), .rst_n(rst_n), .tx_stat_valid(tx_valid), .tx_stat_vec(tx_vec),
        .rx_stat_valid(rx_valid), .rx_stat_vec(rx_vec), .host_req(host_req),
        .host_addr(host_addr), .rd_valid(s_valid), .rd_hi(s_hi), .rd_data(s_data));

    typedef struct {
        logic [5:0]      a;
        longint unsigned v;
        longint unsigned sv;
        int              t;
        string           tag;
    } exp_t;

    exp_t            q[$];
    longint unsigned model [64];
    int              checks = 0, fails = 0, bursts = 0, cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int bin_of(input int len);
        if (len < 64)        return -1;
        else if (len == 64)  return 0;
        else if (len <= 127) return 1;
        else if (len <= 255) return 2;
        else if (len <= 511) return 3;
        else if (len <= 1023) return 4;
        return 5;
    endfunction

    function automatic logic [28:0] rxv(input int len, input logic [28:0] fl);
        return fl | (29'(len) << 5);
    endfunction

    function automatic logic [24:0] txv(input int len, input logic [24:0] fl);
        return fl | (25'(len) << 5);
    endfunction

    // reference update for one receive frame, from R2/R3/R4/R6
    task automatic rx_apply(input logic [28:0] v);
        int len = int'(v[18:5]);
        int b   = bin_of(len);
        model[18] += longint'(len);
        if (v[2])  model[1]++;
        if (v[28]) model[11]++;
        if (v[27]) model[14]++;
        if (len < 64) begin
            if (v[2]) model[17]++; else model[16]++;
        end
        if (v[0]) begin
            model[0]++;
            if (v[3])  model[2]++;
            if (v[4])  model[3]++;
            if (v[19]) model[10]++;
            if (v[21]) model[12]++;
            if (v[26]) model[13]++;
            if (v[20]) model[15]++;
            if (b >= 0) model[4 + b]++;
        end
    endtask

    // reference update for one transmit frame, from R5/R6
    task automatic tx_apply(input logic [24:0] v);
        int len = int'(v[18:5]);
        int b   = bin_of(len);
        model[19] += longint'(len);
        if (v[3]) model[35]++;
        if (v[0]) begin
            model[32]++;
            if (v[1])  model[33]++;
            if (v[2])  model[34]++;
            if (v[4])  model[36]++;
            if (v[19]) model[43]++;
            if (v[24]) model[44]++;
            if (len > 1518) model[45]++;
            if (b >= 0) model[37 + b]++;
        end
    endtask

    task automatic send(input logic rv, input logic [28:0] r, input logic tv, input logic [24:0] t);
        @(negedge clk);
        rx_valid = rv; rx_vec = r; tx_valid = tv; tx_vec = t;
        if (rv) rx_apply(r);
        if (tv) tx_apply(t);
    endtask

    task automatic idle();
        @(negedge clk);
        rx_valid = 1'b0; tx_valid = 1'b0; rx_vec = '0; tx_vec = '0;
    endtask

    function automatic string tag_of(input logic [5:0] a);
        if (a == 6'h12 || a == 6'h13)          return "R6";
        if (a >= 6'h04 && a <= 6'h09)          return "R4";
        if (a == 6'h01 || a == 6'h0B || a == 6'h0E || a == 6'h10 || a == 6'h11) return "R3";
        if (a < 6'h14)                         return "R2";
        if (a >= 6'h20 && a <= 6'h2D)          return "R5";
        return "R10";
    endfunction

    task automatic push_exp(input logic [5:0] a, input string tag);
        exp_t e;
        e.a   = a;
        e.v   = model[a];
        e.sv  = (model[a] > SAT_MAX) ? SAT_MAX : model[a];
        e.t   = cyc;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_read(input logic [5:0] a, input string tag);
        @(negedge clk);
        host_req = 1'b1; host_addr = a;
        push_exp(a, tag);
        @(negedge clk);
        host_req = 1'b0;
        repeat (9) @(negedge clk);
        check(rd_valid == 1'b0, "R7", "valid low after burst", 64'(rd_valid), 0);
    endtask

    // monitor: pops one expectation per two-word burst
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "word with no pending request", 64'(rd_data), 0);
            end else if (!rd_hi) begin
                check(cyc == q[0].t + 7, "R7", "low word latency", longint'(cyc), longint'(q[0].t + 7));
                check(rd_data == q[0].v[31:0], q[0].tag, $sformatf("low word @0x%0h", q[0].a),
                      64'(rd_data), 64'(q[0].v[31:0]));
                check(s_data == q[0].sv[31:0], "R9", $sformatf("narrow low word @0x%0h", q[0].a),
                      64'(s_data), 64'(q[0].sv[31:0]));
            end else begin
                check(rd_data == q[0].v[63:32], q[0].tag, $sformatf("high word @0x%0h", q[0].a),
                      64'(rd_data), 64'(q[0].v[63:32]));
                check(s_data == 32'h0, "R9", "narrow high word", 64'(s_data), 0);
                void'(q.pop_front());
                bursts++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int nb;
        foreach (model[i]) model[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs and zero counters after reset
        check(rd_valid == 1'b0 && rd_hi == 1'b0, "R1", "outputs after reset", 64'({rd_valid, rd_hi}), 0);
        do_read(6'h00, "R1");
        do_read(6'h12, "R1");
        do_read(6'h2D, "R1");

        // receive traffic, some with transmit in the same cycle
        send(1, rxv(64,  F_GOOD | F_BC | F_VLAN), 0, '0);
        send(1, rxv(100, F_GOOD | F_MC | F_CTL | F_FC), 1, txv(64, G_OK | G_BC));
        send(1, rxv(2000, F_GOOD | F_OOB), 0, '0);
        send(1, rxv(300, F_BAD | F_FCS | F_BC), 1, txv(130, G_OK | G_MC | G_VLAN));
        send(1, rxv(40,  F_BAD | F_FCS), 0, '0);
        send(1, rxv(50,  F_BAD), 1, txv(600, G_OK | G_CTL | G_PAU));
        send(1, rxv(63,  F_GOOD), 0, '0);
        send(1, rxv(500, F_BAD | F_BOP | F_LTR), 1, txv(1600, G_OK));
        send(1, rxv(127, F_GOOD), 1, txv(1000, G_UND | G_BC));
        send(1, rxv(128, F_GOOD), 1, txv(1518, G_OK));
        send(1, rxv(255, F_GOOD), 1, txv(65, G_OK));
        send(1, rxv(256, F_GOOD), 1, txv(1024, G_OK | G_MC));
        send(1, rxv(511, F_GOOD), 0, '0);
        send(1, rxv(512, F_GOOD), 1, txv(1023, G_OK));
        send(1, rxv(1023, F_GOOD), 0, '0);
        send(1, rxv(1024, F_GOOD), 1, txv(40, G_OK));
        idle();
        // R11: vectors without strobes must not count
        send(0, '1, 0, '1);
        idle();
        do_read(6'h12, "R11");
        do_read(6'h20, "R11");
        do_read(6'h00, "R11");

        for (int a = 0; a < 20; a++) do_read(6'(a), tag_of(6'(a)));
        for (int a = 32; a < 46; a++) do_read(6'(a), tag_of(6'(a)));
        // R10: unmapped addresses
        do_read(6'h14, "R10");
        do_read(6'h1F, "R10");
        do_read(6'h2E, "R10");
        do_read(6'h3F, "R10");

        // R8: a second request inside a burst is dropped
        nb = bursts;
        @(negedge clk);
        host_req = 1'b1; host_addr = 6'h00;
        push_exp(6'h00, "R8");
        @(negedge clk);
        host_req = 1'b0;
        repeat (2) @(negedge clk);
        host_req = 1'b1; host_addr = 6'h20;
        @(negedge clk);
        host_req = 1'b0;
        repeat (12) @(negedge clk);
        check(bursts == nb + 1 && q.size() == 0, "R8", "bursts for overlapped requests",
              longint'(bursts - nb), 1);

        // R9: fill the narrow instance's transmit byte counter past its ceiling
        for (int i = 0; i < 70; i++) send(0, '0, 1, txv(16383, '0));
        idle();
        do_read(6'h13, "R9");
        do_read(6'h12, "R9");

        // R1: a later reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        foreach (model[i]) model[i] = 0;
        do_read(6'h13, "R1");
        do_read(6'h20, "R1");

        check(q.size() == 0, "R7", "pending expectations at end", longint'(q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule